// File: doc/BRIEF.md
# GF(2^128) Multiply-and-Reduce Engine

This block multiplies two elements of the binary field GF(2^128) in polynomial basis and returns the reduced 128-bit product. The field polynomial is f(z) = z^128 + z^7 + z^2 + z + 1. Bit i of every 128-bit port is the coefficient of z^i. A square-mode input makes the block use the first operand for both factors, so squaring runs through the same multiplier.

A caller presents the operands, pulses `start` while the engine is idle, and waits for `done`. The unreduced product of up to 255 bits is built from three 64-bit carry-less sub-products in a Karatsuba arrangement. It is then reduced in two folds. In each fold, the bits of degree 128 and above are multiplied by the 8-bit polynomial z^7+z^2+z+1 in a narrow carry-less multiplier and XORed back into the lower bits.

Top module: `gf128_mul`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `busy` and `done` are 0 and `result` is all zeros.
- R2: `start` is accepted on a rising clock edge where `busy` is 0. After that edge, `busy` is 1 for three cycles. On the third edge after the accepting edge, `busy` falls and `done` rises for exactly one cycle.
- R3: The `result` presented with `done` equals `opA`·`opB` reduced modulo z^128 + z^7 + z^2 + z + 1, with bit i of each port holding the coefficient of z^i.
- R4: When `squareMode` is 1 at the accepting edge, the result is `opA`·`opA` mod f, and `opB` has no effect on it.
- R5: A `start` pulse seen while `busy` is 1 is ignored: the running operation's result is unchanged and no extra `done` pulse occurs.
- R6: `result` changes only on the edge that raises `done`, and otherwise holds its last value.
- R7: Multiplying any element by 1 (only bit 0 set) returns that element. Multiplying by 0 returns 0, whichever operand is zero.
- R8: Products that reach degree 254 are fully reduced. This holds for all-ones operands and for z^127·z^127, both of which need both folding rounds.
- R9: The operands and `squareMode` are sampled only at the accepting edge. Changing them while `busy` is 1 does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| squareMode | input | 1 | 1: square `opA`; 0: multiply `opA` by `opB` |
| opA | input | 128 | First field element |
| opB | input | 128 | Second field element (unused in square mode) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a valid `result` |
| result | output | 128 | Reduced product |

## Verification
The assertions cover the handshake timing on every cycle. An accepted `start` must raise `busy`. A falling `busy` and a `done` pulse must always coincide. `done` may never last two cycles, and `result` may not move outside a `done` edge. Arithmetic correctness needs directed scenarios compared against a bit-serial shift-and-reduce model. These include the identities with 1 and 0, square mode with a junk `opB`, and degree-254 products that exercise the second fold. Only the scenarios can show that `start` pulses during a busy period are dropped and that operand changes after acceptance are ignored.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  // strobes from the sequencer to the datapath, one per pipeline capture
  typedef struct packed {
    logic loadOps;
    logic capProd;
    logic capFold;
    logic capResult;
  } gfmStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MUL   = 2'd1,
    ST_FOLD1 = 2'd2,
    ST_FOLD2 = 2'd3
  } gfmState_t;

endpackage

// File: rtl/gfm_clmul.sv
// Carry-less (XOR-accumulate) multiply of a wide operand by a narrow one.
module gfm_clmul #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 64,
  localparam int OUT_W   = WIDE_W + NARROW_W - 1
) (
  input  logic [WIDE_W-1:0]   opWide,
  input  logic [NARROW_W-1:0] opNarrow,
  output logic [OUT_W-1:0]    prod
);

  always_comb begin
    prod = '0;
    for (int i = 0; i < NARROW_W; i++) begin
      if (opNarrow[i]) prod = prod ^ (OUT_W'(opWide) << i);
    end
  end

endmodule

// File: rtl/gfm_ctrl.sv
// Sequencer: idle -> product -> first fold -> second fold -> idle.
module gfm_ctrl
  import gfm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output gfmStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  gfmState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        strobe.loadOps = start;
        if (start) stateNext = ST_MUL;
      end
      ST_MUL: begin
        strobe.capProd = 1'b1;
        stateNext      = ST_FOLD1;
      end
      ST_FOLD1: begin
        strobe.capFold = 1'b1;
        stateNext      = ST_FOLD2;
      end
      ST_FOLD2: begin
        strobe.capResult = 1'b1;
        stateNext        = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.capResult;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/gfm_datapath.sv
// Karatsuba product of two field elements, then two narrow folding rounds.
module gfm_datapath
  import gfm_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int R_W    = 8,
  parameter logic [R_W-1:0] R_POLY = 8'h87,
  localparam int FIELD_W = 2 * HALF_W,
  localparam int SUB_W   = 2 * HALF_W - 1,
  localparam int PROD_W  = 2 * FIELD_W - 1,
  localparam int HI_W    = PROD_W - FIELD_W,
  localparam int FOLD_W  = HI_W + R_W - 1,
  localparam int EX_W    = FOLD_W - FIELD_W,
  localparam int EXP_W   = EX_W + R_W - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  gfmStrobe_t         strobe,
  input  logic               squareMode,
  input  logic [FIELD_W-1:0] opA,
  input  logic [FIELD_W-1:0] opB,
  output logic [FIELD_W-1:0] result
);

  logic [FIELD_W-1:0] aReg, bReg;
  logic [PROD_W-1:0]  prodReg, prodComb;
  logic [FOLD_W-1:0]  foldReg, foldComb, fold1Prod;
  logic [EXP_W-1:0]   fold2Prod;
  logic [FIELD_W-1:0] resComb;

  // sub-product operands: 0 = low halves, 1 = high halves, 2 = half sums
  logic [HALF_W-1:0] subA [3];
  logic [HALF_W-1:0] subB [3];
  logic [SUB_W-1:0]  subP [3];
  logic [SUB_W-1:0]  midTerm;

  assign subA[0] = aReg[HALF_W-1:0];
  assign subB[0] = bReg[HALF_W-1:0];
  assign subA[1] = aReg[FIELD_W-1:HALF_W];
  assign subB[1] = bReg[FIELD_W-1:HALF_W];
  assign subA[2] = aReg[HALF_W-1:0] ^ aReg[FIELD_W-1:HALF_W];
  assign subB[2] = bReg[HALF_W-1:0] ^ bReg[FIELD_W-1:HALF_W];

  for (genvar g = 0; g < 3; g++) begin : g_sub
    gfm_clmul #(.WIDE_W(HALF_W), .NARROW_W(HALF_W)) subMul_i (
      .opWide  (subA[g]),
      .opNarrow(subB[g]),
      .prod    (subP[g])
    );
  end

  assign midTerm  = subP[2] ^ subP[0] ^ subP[1];
  assign prodComb = PROD_W'(subP[0])
                  ^ (PROD_W'(subP[1]) << FIELD_W)
                  ^ (PROD_W'(midTerm) << HALF_W);

  // first fold: everything at degree >= FIELD_W times r(z)
  gfm_clmul #(.WIDE_W(HI_W), .NARROW_W(R_W)) fold1Mul_i (
    .opWide  (prodReg[PROD_W-1:FIELD_W]),
    .opNarrow(R_POLY),
    .prod    (fold1Prod)
  );
  assign foldComb = fold1Prod ^ FOLD_W'(prodReg[FIELD_W-1:0]);

  // second fold: the few bits the first fold pushed past degree FIELD_W-1
  gfm_clmul #(.WIDE_W(EX_W), .NARROW_W(R_W)) fold2Mul_i (
    .opWide  (foldReg[FOLD_W-1:FIELD_W]),
    .opNarrow(R_POLY),
    .prod    (fold2Prod)
  );
  assign resComb = foldReg[FIELD_W-1:0] ^ FIELD_W'(fold2Prod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      prodReg <= '0;
      foldReg <= '0;
      result  <= '0;
    end else begin
      if (strobe.loadOps) begin
        aReg <= opA;
        bReg <= squareMode ? opA : opB;
      end
      if (strobe.capProd)   prodReg <= prodComb;
      if (strobe.capFold)   foldReg <= foldComb;
      if (strobe.capResult) result  <= resComb;
    end
  end

endmodule

// File: rtl/gf128_mul.sv
module gf128_mul
  import gfm_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int R_W    = 8,
  parameter logic [R_W-1:0] R_POLY = 8'h87
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  squareMode,
  input  logic [2*HALF_W-1:0]   opA,
  input  logic [2*HALF_W-1:0]   opB,
  output logic                  busy,
  output logic                  done,
  output logic [2*HALF_W-1:0]   result
);

  gfmStrobe_t strobe;

  gfm_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  gfm_datapath #(.HALF_W(HALF_W), .R_W(R_W), .R_POLY(R_POLY)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .squareMode(squareMode),
    .opA       (opA),
    .opB       (opB),
    .result    (result)
  );

endmodule

// File: rtl/gf128_mul_chk.sv
module gf128_mul_chk #(
  parameter int FIELD_W = 128
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [FIELD_W-1:0] result
);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_done_on_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $fell(busy));

  assert_fall_gives_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

endmodule

bind gf128_mul gf128_mul_chk #(.FIELD_W(2*HALF_W)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .result(result)
);

// File: tb/gf128_mul_tb_top.sv
`timescale 1ns/1ps
module gf128_mul_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         squareMode = 1'b0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic         busy, done;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gf128_mul dut_i (
    .clk(clk), .rstN(rstN), .start(start), .squareMode(squareMode),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .result(result)
  );

  // bit-serial model: Horner over b, reducing by z^128 = z^7+z^2+z+1 each step
  function automatic logic [127:0] refMul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] acc = '0;
    for (int i = 127; i >= 0; i--) begin
      acc = acc[127] ? ((acc << 1) ^ 128'h87) : (acc << 1);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [63:0] nextRand(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {126'b0, busy, done}, '0);
    chk(result === '0, "R1 result in reset", result, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 flags after release", {126'b0, busy, done}, '0);
    chk(result === '0, "R1 result after release", result, '0);
  endtask

  // mode 0: plain; mode 1: start pulses while busy (R5); mode 2: operands change while busy (R9)
  task automatic runOp(input logic [127:0] a, input logic [127:0] b, input logic sq,
                       input int mode, input string req);
    logic [127:0] exp = refMul(a, sq ? a : b);
    @(negedge clk);
    opA = a; opB = b; squareMode = sq; start = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(busy === 1'b1 && done === 1'b0, "R2 busy window", {126'b0, busy, done}, 128'b10);
      start = 1'b0;
      if (mode == 1 && k < 3) begin
        start = 1'b1; opA = ~a; opB = b ^ 128'h5a; squareMode = ~sq;
      end else if (mode == 2) begin
        opA = ~a; opB = ~b; squareMode = ~sq;
      end
    end
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R2 done pulse", {126'b0, busy, done}, 128'b01);
    chk(result === exp, req, result, exp);
    @(negedge clk);
    chk(done === 1'b0, "R2 R5 done single cycle", {127'b0, done}, '0);
    chk(result === exp, "R6 result held", result, exp);
  endtask

  initial begin
    logic [63:0] seed = 64'h9e3779b97f4a7c15;
    logic [127:0] x, y;
    testReset();
    // R7 identities
    runOp(128'hfedcba98_76543210_0f1e2d3c_4b5a6978, 128'h1, 1'b0, 0, "R7 a*1");
    runOp(128'hfedcba98_76543210_0f1e2d3c_4b5a6978, 128'h0, 1'b0, 0, "R7 a*0");
    runOp(128'h0, 128'h13579bdf_2468ace0_deadbeef_cafef00d, 1'b0, 0, "R7 0*b");
    // R3 general products
    for (int n = 0; n < 6; n++) begin
      seed = nextRand(seed); x[127:64] = seed;
      seed = nextRand(seed); x[63:0]   = seed;
      seed = nextRand(seed); y[127:64] = seed;
      seed = nextRand(seed); y[63:0]   = seed;
      runOp(x, y, 1'b0, 0, "R3 product");
    end
    runOp(128'h2, 128'h1 << 127, 1'b0, 0, "R3 z*z^127");
    // R4 squaring, opB junk
    runOp(x, 128'hffff_0000_ffff_0000_ffff_0000_ffff_0000, 1'b1, 0, "R4 square");
    runOp(128'h1 << 127, y, 1'b1, 0, "R4 square top bit");
    // R8 degree-254 products
    runOp('1, '1, 1'b0, 0, "R8 all ones");
    runOp(128'h1 << 127, 128'h1 << 127, 1'b0, 0, "R8 z^127 squared");
    // R5 start while busy
    runOp(x, y, 1'b0, 1, "R5 start ignored while busy");
    // R9 operands sampled once
    runOp(y, x, 1'b0, 2, "R9 operands latched");
    runOp(x, y, 1'b1, 2, "R9 square mode latched");
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    summary();
  end

endmodule